// File: doc/BRIEF.md
# Power Management Function Register Decoder

This block holds the configuration space of a power-management function on a PCI bus. It has a 32-bit configuration port with byte enables. Reads from that port are combinational, and writes take effect at the next clock edge. Two of its doublewords are I/O base registers. One places a 128-byte power-management window and the other places a 16-byte SMBus window. Every write that touches either base register makes that register rewrite itself: the low address bits are cleared, the bits above the 16-bit I/O range are cleared, and the I/O-space indicator in bit 0 is forced to 1. An enable bit elsewhere in configuration space switches each window on or off.

From a 16-bit I/O address, the block produces a combinational hit signal for each window. The power-management window is only hit by single-byte accesses. The block also holds the four implemented power-management event status bits and their enable bits. Each status bit is set by a pulse on its own event input and is cleared by writing 1 to it. The block drives a system control interrupt level from the enabled, pending events. That level is gated by the interrupt-pin byte. It also drives an arm signal that tells an external power-management timer whether its overflow should be scheduled.

Top module: `pm_func_regs`

## Requirements
- R1: After reset, every configuration doubleword from 0x40 to 0xFC reads 0, except 0x48 and 0x90, which read 0x00000001. The interrupt-pin byte at 0x3D reads 0x01. pmEnable, smbEnable, pm1Sts, pm1En and sci are all 0.
- R2: A write with any byte enable set to doubleword 0x48 first merges the enabled bytes into the old value. It then stores (merged AND 0x0000FF80) OR 1. pmBase equals bits 15:0 of that register AND 0xFF80.
- R3: A write with any byte enable set to doubleword 0x90 merges in the same way. It then stores (merged AND 0x0000FFF0) OR 1. smbBase equals bits 15:0 of that register AND 0xFFF0.
- R4: A write to byte 0xD2 (byte lane 2 of doubleword 0xD0) keeps only bits 3:0 of the written value. All other bytes from 0x40 to 0xFF store exactly what is written, in the byte lanes that are enabled. Lanes that are not enabled keep their old value.
- R5: pmEnable is bit 7 of byte 0x41 (bit 15 of doubleword 0x40). pmHit is high exactly when pmEnable is 1, ioSingle is 1, and (ioAddr AND 0xFF80) equals pmBase.
- R6: smbEnable is bit 0 of byte 0xD2. smbHit is high exactly when smbEnable is 1 and (ioAddr AND 0xFFF0) equals smbBase. The value of ioSingle does not affect smbHit.
- R7: Byte 0x3D (lane 1 of doubleword 0x3C) is writable. It reads back in bits 15:8 of doubleword 0x3C. Every other byte below 0x40 reads 0 and ignores writes.
- R8: pm1Sts implements four bits: timer at bit 0, global lock at bit 5, power button at bit 8 and RTC at bit 10. pm1Event bits 0 to 3 set these bits, in that order, at the next edge. A cycle with pm1StsClrEn clears every implemented bit that is 1 in pm1WrData. If an event and a clear hit the same bit in the same cycle, the event wins. Unimplemented bits read 0.
- R9: A cycle with pm1EnWrEn stores pm1WrData AND 0x0521 into pm1En.
- R10: sci is 1 exactly when the interrupt-pin byte is nonzero and (pm1Sts AND pm1En) is nonzero.
- R11: tmrArm is 1 exactly when pm1En bit 0 is 1 and pm1Sts bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address; bits 1:0 ignored |
| cfgByteEn | input | 4 | Byte-lane enables for writes |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Doubleword at cfgAddr (combinational) |
| ioAddr | input | 16 | I/O bus address to decode |
| ioSingle | input | 1 | Current I/O access is one byte wide |
| pmEnable | output | 1 | Power-management window enabled |
| pmBase | output | 16 | Power-management window base |
| pmHit | output | 1 | ioAddr falls in the power-management window |
| smbEnable | output | 1 | SMBus window enabled |
| smbBase | output | 16 | SMBus window base |
| smbHit | output | 1 | ioAddr falls in the SMBus window |
| pm1Event | input | 4 | Event pulses: timer, global lock, power button, RTC |
| pm1StsClrEn | input | 1 | Write-1-to-clear strobe for the status bits |
| pm1EnWrEn | input | 1 | Write strobe for the enable bits |
| pm1WrData | input | 16 | Data for the status clear and enable write |
| pm1Sts | output | 16 | Event status bits |
| pm1En | output | 16 | Event enable bits |
| sci | output | 1 | System control interrupt level |
| tmrArm | output | 1 | Arm the timer overflow |

## Verification
A wrong base filter or byte merge shows up on the very next configuration read. It also shows up at once on pmBase or smbBase, and one cycle after the write it moves the edges of the window hits. The bench therefore reads back every written doubleword and probes addresses just inside and just outside each window. A status bit that is stuck, or that is cleared when it should be set, appears on pm1Sts one cycle after the event or clear pulse. It also appears on sci and tmrArm in that same cycle, so those are compared after every step.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int CfgAddrW = 8;
  localparam int DwIdxW = CfgAddrW - 2;
  localparam int NumEvt = 4;

  typedef struct packed {
    logic              genWr;
    logic [3:0]        be;
    logic [DwIdxW-1:0] dwIdx;
    logic              pinWr;
    logic              stsClr;
    logic              enWr;
  } cfgStrobe_t;

  function automatic int evtPos(int e);
    case (e)
      0: return 0;
      1: return 5;
      2: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [15:0] implMask();
    logic [15:0] m;
    m = '0;
    for (int e = 0; e < NumEvt; e++) m[evtPos(e)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] mergeBe(logic [31:0] oldV, logic [31:0] newV, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? newV[8*b +: 8] : oldV[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
#(
  parameter int CfgLo   = 64,
  parameter int PinAddr = 61
) (
  input  logic                cfgWrEn,
  input  logic [CfgAddrW-1:0] cfgAddr,
  input  logic [3:0]          cfgByteEn,
  input  logic                pm1StsClrEn,
  input  logic                pm1EnWrEn,
  output cfgStrobe_t          strb
);
  localparam logic [DwIdxW-1:0] LoDw  = DwIdxW'(CfgLo / 4);
  localparam logic [DwIdxW-1:0] PinDw = DwIdxW'(PinAddr / 4);
  localparam int PinLane = PinAddr % 4;

  logic [DwIdxW-1:0] addrDw;
  assign addrDw = cfgAddr[CfgAddrW-1:2];

  always_comb begin
    strb.genWr  = cfgWrEn && (|cfgByteEn) && (addrDw >= LoDw);
    strb.be     = cfgByteEn;
    strb.dwIdx  = addrDw - LoDw;
    strb.pinWr  = cfgWrEn && (addrDw == PinDw) && cfgByteEn[PinLane];
    strb.stsClr = pm1StsClrEn;
    strb.enWr   = pm1EnWrEn;
  end
endmodule

// File: rtl/pmf_datapath.sv
module pmf_datapath
  import pmf_pkg::*;
#(
  parameter int          CfgLo      = 64,
  parameter int          PmBarAddr  = 72,
  parameter int          SmbBarAddr = 144,
  parameter int          SmbCtlAddr = 210,
  parameter int          PmEnAddr   = 65,
  parameter int          PmEnBit    = 7,
  parameter int          PinAddr    = 61,
  parameter logic [7:0]  PinInit    = 8'h01,
  parameter logic [7:0]  SmbCtlKeep = 8'h0F,
  parameter int          IoAddrW    = 16,
  parameter int          PmWinBits  = 7,
  parameter int          SmbWinBits = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strb,
  input  logic [CfgAddrW-1:0] cfgAddr,
  input  logic [31:0]         cfgWrData,
  output logic [31:0]         cfgRdData,
  input  logic [IoAddrW-1:0]  ioAddr,
  input  logic                ioSingle,
  output logic                pmEnable,
  output logic [IoAddrW-1:0]  pmBase,
  output logic                pmHit,
  output logic                smbEnable,
  output logic [IoAddrW-1:0]  smbBase,
  output logic                smbHit,
  input  logic [NumEvt-1:0]   pm1Event,
  input  logic [15:0]         pm1WrData,
  output logic [15:0]         pm1Sts,
  output logic [15:0]         pm1En,
  output logic                sci,
  output logic                tmrArm
);
  localparam int NumDw    = ((1 << CfgAddrW) - CfgLo) / 4;
  localparam int PmDw     = (PmBarAddr - CfgLo) / 4;
  localparam int SmbDw    = (SmbBarAddr - CfgLo) / 4;
  localparam int CtlDw    = (SmbCtlAddr - CfgLo) / 4;
  localparam int CtlLane  = SmbCtlAddr % 4;
  localparam int EnDw     = (PmEnAddr - CfgLo) / 4;
  localparam int EnPos    = 8 * (PmEnAddr % 4) + PmEnBit;
  localparam int PinLane  = PinAddr % 4;
  localparam logic [31:0] IoMask  = (32'd1 << IoAddrW) - 32'd1;
  localparam logic [31:0] PmMask  = IoMask & ~((32'd1 << PmWinBits) - 32'd1);
  localparam logic [31:0] SmbMask = IoMask & ~((32'd1 << SmbWinBits) - 32'd1);
  localparam logic [31:0] CtlMask = ~(32'(8'hFF & ~SmbCtlKeep) << (8 * CtlLane));
  localparam logic [15:0] EvtMask = implMask();
  localparam int TmrPos = evtPos(0);

  logic [31:0] dwReg [NumDw];
  logic [7:0]  intPin;

  // configuration doublewords, each with its own write filter
  for (genvar g = 0; g < NumDw; g++) begin : gDw
    logic [31:0] mrg, nxt;
    assign mrg = mergeBe(dwReg[g], cfgWrData, strb.be);
    if (g == PmDw) begin : gPm
      assign nxt = (mrg & PmMask) | 32'd1;
    end else if (g == SmbDw) begin : gSmb
      assign nxt = (mrg & SmbMask) | 32'd1;
    end else if (g == CtlDw) begin : gCtl
      assign nxt = mrg & CtlMask;
    end else begin : gPlain
      assign nxt = mrg;
    end
    always_ff @(posedge clk) begin
      if (!rstN) dwReg[g] <= (g == PmDw || g == SmbDw) ? 32'd1 : 32'd0;
      else if (strb.genWr && strb.dwIdx == DwIdxW'(g)) dwReg[g] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) intPin <= PinInit;
    else if (strb.pinWr) intPin <= cfgWrData[8*PinLane +: 8];
  end

  // read mux
  logic [DwIdxW-1:0] rdDw, rdIdx;
  assign rdDw  = cfgAddr[CfgAddrW-1:2];
  assign rdIdx = rdDw - DwIdxW'(CfgLo / 4);
  always_comb begin
    if (rdDw >= DwIdxW'(CfgLo / 4)) cfgRdData = dwReg[rdIdx];
    else if (rdDw == DwIdxW'(PinAddr / 4)) cfgRdData = 32'(intPin) << (8 * PinLane);
    else cfgRdData = '0;
  end

  // window decode
  logic [31:0] pmDwV, smbDwV;
  assign pmDwV     = dwReg[PmDw];
  assign smbDwV    = dwReg[SmbDw];
  assign pmBase    = pmDwV[IoAddrW-1:0] & PmMask[IoAddrW-1:0];
  assign smbBase   = smbDwV[IoAddrW-1:0] & SmbMask[IoAddrW-1:0];
  assign pmEnable  = dwReg[EnDw][EnPos];
  assign smbEnable = dwReg[CtlDw][8*CtlLane];
  assign pmHit  = pmEnable && ioSingle && ((ioAddr & PmMask[IoAddrW-1:0]) == pmBase);
  assign smbHit = smbEnable && ((ioAddr & SmbMask[IoAddrW-1:0]) == smbBase);

  // event status and enable
  logic [15:0] setBits, stsNext;
  always_comb begin
    setBits = '0;
    for (int e = 0; e < NumEvt; e++) setBits[evtPos(e)] = pm1Event[e];
    stsNext = ((pm1Sts & ~(strb.stsClr ? pm1WrData : 16'h0)) | setBits) & EvtMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pm1Sts <= '0;
      pm1En  <= '0;
    end else begin
      pm1Sts <= stsNext;
      if (strb.enWr) pm1En <= pm1WrData & EvtMask;
    end
  end

  assign sci    = (intPin != 8'h00) && (|(pm1Sts & pm1En & EvtMask));
  assign tmrArm = pm1En[TmrPos] && !pm1Sts[TmrPos];

  // checks
  assert_pmbar_fmt_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.genWr && strb.dwIdx == DwIdxW'(PmDw)) |-> ((pmDwV & ~PmMask) == 32'd1));
  assert_smbbar_fmt_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.genWr && strb.dwIdx == DwIdxW'(SmbDw)) |-> ((smbDwV & ~SmbMask) == 32'd1));
  assert_pmhit_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    pmHit |-> (pmEnable && ioSingle));
  assert_w1c_timer_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.stsClr && pm1WrData[TmrPos] && !pm1Event[0]) |-> !pm1Sts[TmrPos]);
  assert_evt_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(pm1Event[NumEvt-1]) |-> pm1Sts[evtPos(NumEvt-1)]);
  assert_sci_pin_R10: assert property (@(posedge clk) disable iff (!rstN)
    sci |-> (intPin != 8'h00));
  assert_arm_R11: assert property (@(posedge clk) disable iff (!rstN)
    tmrArm |-> !pm1Sts[TmrPos]);
endmodule

// File: rtl/pm_func_regs.sv
module pm_func_regs
  import pmf_pkg::*;
#(
  parameter int IoAddrW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [7:0]         cfgAddr,
  input  logic [3:0]         cfgByteEn,
  input  logic [31:0]        cfgWrData,
  output logic [31:0]        cfgRdData,
  input  logic [IoAddrW-1:0] ioAddr,
  input  logic               ioSingle,
  output logic               pmEnable,
  output logic [IoAddrW-1:0] pmBase,
  output logic               pmHit,
  output logic               smbEnable,
  output logic [IoAddrW-1:0] smbBase,
  output logic               smbHit,
  input  logic [3:0]         pm1Event,
  input  logic               pm1StsClrEn,
  input  logic               pm1EnWrEn,
  input  logic [15:0]        pm1WrData,
  output logic [15:0]        pm1Sts,
  output logic [15:0]        pm1En,
  output logic               sci,
  output logic               tmrArm
);
  localparam int CfgLo   = 64;
  localparam int PinAddr = 61;

  cfgStrobe_t strb;

  pmf_ctrl #(.CfgLo(CfgLo), .PinAddr(PinAddr)) i_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .pm1StsClrEn(pm1StsClrEn), .pm1EnWrEn(pm1EnWrEn), .strb(strb)
  );

  pmf_datapath #(.CfgLo(CfgLo), .PinAddr(PinAddr), .IoAddrW(IoAddrW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ioAddr(ioAddr), .ioSingle(ioSingle),
    .pmEnable(pmEnable), .pmBase(pmBase), .pmHit(pmHit),
    .smbEnable(smbEnable), .smbBase(smbBase), .smbHit(smbHit),
    .pm1Event(pm1Event), .pm1WrData(pm1WrData),
    .pm1Sts(pm1Sts), .pm1En(pm1En), .sci(sci), .tmrArm(tmrArm)
  );
endmodule

// File: tb/test_pm_func_regs.sv
module test_pm_func_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [15:0] ioAddr = '0;
  logic ioSingle = 1'b1;
  logic pmEnable, pmHit, smbEnable, smbHit, sci, tmrArm;
  logic [15:0] pmBase, smbBase, pm1Sts, pm1En;
  logic [3:0] pm1Event = '0;
  logic pm1StsClrEn = 1'b0;
  logic pm1EnWrEn = 1'b0;
  logic [15:0] pm1WrData = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mem [256];
  logic [15:0] stsM, enM;
  localparam logic [15:0] EvtM = 16'h0521;

  pm_func_regs i_pm_func_regs (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdw(input int a);
    int b;
    b = a & 8'hFC;
    if (b >= 8'h40) return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
    if (b == 8'h3C) return {16'h0, mem[8'h3D], 8'h0};
    return 32'h0;
  endfunction

  task automatic mwrite(input int a, input logic [3:0] be, input logic [31:0] d);
    int b;
    logic [31:0] v;
    b = a & 8'hFC;
    if (b >= 8'h40) begin
      for (int i = 0; i < 4; i++) if (be[i]) mem[b+i] = d[8*i +: 8];
      if (be != 0 && (b == 8'h48 || b == 8'h90)) begin
        v = mdw(b);
        v = (v & ((b == 8'h48) ? 32'h0000FF80 : 32'h0000FFF0)) | 32'd1;
        for (int i = 0; i < 4; i++) mem[b+i] = v[8*i +: 8];
      end
      if (b == 8'hD0 && be[2]) mem[8'hD2] = mem[8'hD2] & 8'h0F;
    end else if (b == 8'h3C && be[1]) mem[8'h3D] = d[15:8];
  endtask

  task automatic cfgWr(input int a, input logic [3:0] be, input logic [31:0] d);
    cfgAddr = 8'(a); cfgByteEn = be; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mwrite(a, be, d);
  endtask

  task automatic cfgChk(input string req, input int a);
    cfgAddr = 8'(a);
    #1;
    chk(req, cfgRdData, mdw(a));
  endtask

  task automatic ioChk(input logic [15:0] a, input logic s);
    logic [15:0] pb, sb;
    logic pe, se;
    pb = {mem[8'h49], mem[8'h48]} & 16'hFF80;
    sb = {mem[8'h91], mem[8'h90]} & 16'hFFF0;
    pe = mem[8'h41][7];
    se = mem[8'hD2][0];
    ioAddr = a; ioSingle = s;
    #1;
    chk("R5 pmEnable", 32'(pmEnable), 32'(pe));
    chk("R5 pmBase", 32'(pmBase), 32'(pb));
    chk("R5 pmHit", 32'(pmHit), 32'(pe && s && ((a & 16'hFF80) == pb)));
    chk("R6 smbEnable", 32'(smbEnable), 32'(se));
    chk("R6 smbBase", 32'(smbBase), 32'(sb));
    chk("R6 smbHit", 32'(smbHit), 32'(se && ((a & 16'hFFF0) == sb)));
  endtask

  task automatic pmChk();
    #1;
    chk("R8 pm1Sts", 32'(pm1Sts), 32'(stsM));
    chk("R9 pm1En", 32'(pm1En), 32'(enM));
    chk("R10 sci", 32'(sci), 32'((mem[8'h3D] != 0) && ((stsM & enM) != 0)));
    chk("R11 tmrArm", 32'(tmrArm), 32'(enM[0] && !stsM[0]));
  endtask

  task automatic pmStep(input logic [3:0] ev, input logic clr, input logic enw, input logic [15:0] d);
    logic [15:0] sb;
    pm1Event = ev; pm1StsClrEn = clr; pm1EnWrEn = enw; pm1WrData = d;
    @(negedge clk);
    pm1Event = '0; pm1StsClrEn = 1'b0; pm1EnWrEn = 1'b0;
    sb = {5'b0, ev[3], 1'b0, ev[2], 2'b0, ev[1], 4'b0, ev[0]};
    stsM = ((stsM & ~(clr ? d : 16'h0)) | sb) & EvtM;
    if (enw) enM = d & EvtM;
    pmChk();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    int picks [7] = '{8'h00, 8'h3C, 8'h40, 8'h48, 8'h90, 8'hD0, 8'h4C};
    int a;
    void'($urandom(32'd1377));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h48] = 8'h01; mem[8'h90] = 8'h01; mem[8'h3D] = 8'h01;
    stsM = '0; enM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int b = 8'h40; b < 256; b += 4) cfgChk("R1 reset cfg", b);
    cfgChk("R1 reset pin", 8'h3C);
    ioChk(16'h0000, 1'b1);
    pmChk();

    // R2 PM base filter
    cfgWr(8'h48, 4'hF, 32'hFFFF_FFFF); cfgChk("R2 pm base all ones", 8'h48);
    chk("R2 pm base value", mdw(8'h48), 32'h0000FF81);
    cfgWr(8'h48, 4'b0100, 32'hFFFF_FFFF); cfgChk("R2 upper byte touch", 8'h48);
    // R3 SMBus base filter
    cfgWr(8'h90, 4'hF, 32'h1234_5678); cfgChk("R3 smb base", 8'h90);
    chk("R3 smb base value", mdw(8'h90), 32'h00005671);
    // R4 control byte filter
    cfgWr(8'hD0, 4'hF, 32'hFFFF_FFFF); cfgChk("R4 ctl byte", 8'hD0);
    chk("R4 ctl value", mdw(8'hD0), 32'hFF0F_FFFF);
    // R5 window enable and edges
    cfgWr(8'h40, 4'b0010, 32'h0000_8000);
    ioChk(16'hFF80, 1'b1); ioChk(16'hFFFF, 1'b1); ioChk(16'hFF7F, 1'b1);
    ioChk(16'hFF80, 1'b0);
    // R6 SMBus edges, width ignored
    ioChk(16'h5670, 1'b0); ioChk(16'h567F, 1'b1); ioChk(16'h5680, 1'b1); ioChk(16'h566F, 1'b0);
    // R7 header ignores writes except pin byte
    cfgWr(8'h00, 4'hF, 32'hDEAD_BEEF); cfgChk("R7 header ignored", 8'h00);
    cfgWr(8'h3C, 4'b1101, 32'hAAAA_AAAA); cfgChk("R7 pin lane not enabled", 8'h3C);
    cfgWr(8'h3C, 4'b0010, 32'h0000_0700); cfgChk("R7 pin written", 8'h3C);

    // R8 R9 R10 R11 directed
    pmStep(4'b0000, 1'b0, 1'b1, 16'hFFFF);
    pmStep(4'b0001, 1'b0, 1'b0, 16'h0);
    pmStep(4'b0001, 1'b1, 1'b0, 16'h0001);
    pmStep(4'b0000, 1'b1, 1'b0, 16'h0001);
    pmStep(4'b1110, 1'b0, 1'b0, 16'h0);
    pmStep(4'b0000, 1'b1, 1'b0, 16'h0100);
    cfgWr(8'h3C, 4'b0010, 32'h0); pmChk();
    cfgWr(8'h3C, 4'b0010, 32'h0000_0100); pmChk();

    // random configuration traffic
    for (int n = 0; n < 400; n++) begin
      a = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) & 8'hFC
                                      : picks[$urandom_range(0, 6)];
      cfgWr(a, 4'($urandom()), $urandom());
      cfgChk("R4 random readback", a);
      ioChk(pmBase | 16'($urandom_range(0, 255)), 1'($urandom()));
      ioChk(smbBase ^ 16'($urandom_range(0, 31)), 1'($urandom()));
    end

    // random event traffic
    for (int n = 0; n < 400; n++) begin
      pmStep(($urandom_range(0, 2) == 0) ? 4'($urandom()) : 4'h0,
             1'($urandom()), ($urandom_range(0, 3) == 0), 16'($urandom()));
    end

    summary();
  end
endmodule